// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes up to four asynchronous external interrupt request pins and turns them into clean, qualified request lines for the downstream priority logic. Each pin is first brought into the clock domain through a synchronizer chain. Its sense mode then decides how the pin is interpreted. Two modes are level modes, active high or active low. The other two capture a rising or a falling edge into a sticky request latch. A per-pin enable and a shared master enable gate each result before it leaves the block.

Software sees all of this as one 32-bit control word behind a simple synchronous write strobe. The word holds the sense modes, the enables, the master enable and a stored critical-routing flag. Four bits of the word act as write-one-to-clear controls. When read, those four bits show the current request state of each pin. Pin 0 drives the critical-level request. Pins 1 to 3 drive the three bits of the main-level request vector.

Top module: `xirq_cond`

## Requirements
- R1: After reset the control word reads 0 and no request output is asserted.
- R2: A write stores bits 23:16 (sense modes), 12 (master enable), 11:8 (pin enables) and 0 (routing flag). These read back unchanged. Bits 31:28, 15:13 and 7:1 always read 0.
- R3: Sense code 00 in field [23-2n:22-2n] makes pin n active-high level sensitive. Its request follows the synchronized pin, and the output responds on the second clock edge after the pin changes.
- R4: Sense code 11 makes pin n active-low level sensitive. Its request is asserted while the synchronized pin is 0.
- R5: Sense code 01 latches a request on a rising edge of the synchronized pin. The request stays set after the pin falls, until it is cleared. The latch is set on the third clock edge after the pin rises.
- R6: Sense code 10 latches a request on a falling edge of the synchronized pin in the same way.
- R7: Writing 1 to bit 27-n clears the edge latch of pin n. Writing 0 to that bit leaves the latch unchanged.
- R8: With enable bit 11-n at 0, pin n drives no output, but its edge latch still captures and reads back. Once the enable is set, the held request appears at the output on the next cycle.
- R9: With master enable bit 12 at 0, no request output is asserted, whatever the pin states and enables.
- R10: Read bit 27-n returns the current request state of pin n. In edge modes this is the latch. In level modes it is the qualified level.
- R11: Pin 0 drives crit_req_o, and pin n (n = 1..3) drives main_req_o[n-1]. Each output is the pin's request ANDed with its enable and the master enable.
- R12: When a clear write and a new capturing edge fall in the same cycle, the new edge wins and the latch stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word and request state |
| pin_i | input | NPIN (4) | Asynchronous external request pins |
| crit_req_o | output | 1 | Critical-level request from pin 0 |
| main_req_o | output | NPIN-1 (3) | Main-level requests from pins 1..3 |

## Verification
The hardest case to reach from the ports is a clear write landing in exactly the cycle in which a fresh edge sets the latch (R12). The bench reaches it by counting the synchronizer and edge-detect registers. It drives the pin on a falling clock edge and presents the clear write two falling edges later, so both act at the same rising edge. A second hard case is an edge captured while its pin is disabled. The bench shows it through the request bit in the read word before it turns the enable on. A behavioural model in the bench tracks every register and is compared against both outputs on every cycle.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   typedef enum logic [1:0] {
      SENSE_LVL_HI = 2'b00,
      SENSE_RISE   = 2'b01,
      SENSE_FALL   = 2'b10,
      SENSE_LVL_LO = 2'b11
   } sense_e;

   localparam int CTRL_W    = 32;
   localparam int CLR_TOP   = 27;
   localparam int MODE_TOP  = 23;
   localparam int MEE_BIT   = 12;
   localparam int EN_TOP    = 11;
   localparam int ROUTE_BIT = 0;

   function automatic int clr_pos(input int n);
      return CLR_TOP - n;
   endfunction

   function automatic int en_pos(input int n);
      return EN_TOP - n;
   endfunction

   function automatic int mode_hi(input int n);
      return MODE_TOP - 2 * n;
   endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("xirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_pin_sense.sv
module xirq_pin_sense
   import xirq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   lvl_i,
   input  sense_e mode_i,
   input  logic   clr_i,
   output logic   pend_o
);
   logic prev_q;
   logic lat_q;
   logic hit;
   logic is_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
      end
   end

   always_comb begin
      unique case (mode_i)
         SENSE_RISE: hit = lvl_i & ~prev_q;
         SENSE_FALL: hit = ~lvl_i & prev_q;
         default:    hit = 1'b0;
      endcase
   end

   assign is_edge = (mode_i == SENSE_RISE) || (mode_i == SENSE_FALL);

   // A new edge takes precedence over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= 1'b0;
      end else if (is_edge) begin
         lat_q <= (lat_q & ~clr_i) | hit;
      end else begin
         lat_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (mode_i)
         SENSE_LVL_HI: pend_o = lvl_i;
         SENSE_LVL_LO: pend_o = ~lvl_i;
         default:      pend_o = lat_q;
      endcase
   end
endmodule

// File: rtl/xirq_ctrl_reg.sv
module xirq_ctrl_reg
   import xirq_pkg::*;
#(
   parameter int NPIN = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [CTRL_W-1:0]         wr_data,
   output logic [NPIN-1:0][1:0]      mode_o,
   output logic [NPIN-1:0]           en_o,
   output logic                      mee_o,
   output logic                      route_o,
   output logic [NPIN-1:0]           clr_o
);
   logic [NPIN-1:0][1:0] mode_q;
   logic [NPIN-1:0]      en_q;
   logic                 mee_q;
   logic                 route_q;
   logic [NPIN-1:0][1:0] mode_d;
   logic [NPIN-1:0]      en_d;
   logic                 unused_wr_bits;

   always_comb begin
      for (int n = 0; n < NPIN; n++) begin
         mode_d[n] = wr_data[mode_hi(n) -: 2];
         en_d[n]   = wr_data[en_pos(n)];
         clr_o[n]  = wr_en & wr_data[clr_pos(n)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         en_q    <= '0;
         mee_q   <= 1'b0;
         route_q <= 1'b0;
      end else if (wr_en) begin
         mode_q  <= mode_d;
         en_q    <= en_d;
         mee_q   <= wr_data[MEE_BIT];
         route_q <= wr_data[ROUTE_BIT];
      end
   end

   assign unused_wr_bits = ^{wr_data[31:28], wr_data[15:13], wr_data[7:1]};

   assign mode_o  = mode_q;
   assign en_o    = en_q;
   assign mee_o   = mee_q;
   assign route_o = route_q;
endmodule

// File: rtl/xirq_cond.sv
module xirq_cond
   import xirq_pkg::*;
#(
   parameter int NPIN        = 4,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NPIN-1:0]   pin_i,
   output logic              crit_req_o,
   output logic [NPIN-2:0]   main_req_o
);
   localparam int NMAIN = NPIN - 1;

   generate
      if (DATA_W != CTRL_W) begin : g_bad_width
         $error("xirq_cond: DATA_W must equal the control word width");
      end
      if (NPIN < 2 || NPIN > 4) begin : g_bad_pins
         $error("xirq_cond: NPIN must be between 2 and 4");
      end
   endgenerate

   logic [NPIN-1:0][1:0] mode;
   logic [NPIN-1:0]      en;
   logic                 mee;
   logic                 route;
   logic [NPIN-1:0]      clr;
   logic [NPIN-1:0]      lvl;
   logic [NPIN-1:0]      pend;
   logic [NPIN-1:0]      req;

   xirq_ctrl_reg #(.NPIN(NPIN)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .mode_o  (mode),
      .en_o    (en),
      .mee_o   (mee),
      .route_o (route),
      .clr_o   (clr)
   );

   generate
      for (genvar n = 0; n < NPIN; n++) begin : g_pin
         xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (pin_i[n]),
            .q_o   (lvl[n])
         );

         xirq_pin_sense u_sense (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[n]),
            .mode_i (sense_e'(mode[n])),
            .clr_i  (clr[n]),
            .pend_o (pend[n])
         );

         assign req[n] = pend[n] & en[n] & mee;
      end
   endgenerate

   assign crit_req_o = req[0];
   assign main_req_o = req[NMAIN:1];

   always_comb begin
      rd_data            = '0;
      rd_data[MEE_BIT]   = mee;
      rd_data[ROUTE_BIT] = route;
      for (int n = 0; n < NPIN; n++) begin
         rd_data[clr_pos(n)]      = pend[n];
         rd_data[mode_hi(n) -: 2] = mode[n];
         rd_data[en_pos(n)]       = en[n];
      end
   end
endmodule

// File: rtl/xirq_cond_chk.sv
module xirq_cond_chk #(
   parameter int NPIN   = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              crit_req_o,
   input logic [NPIN-2:0]   main_req_o
);
   // R9: master enable low silences every output
   a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[12] |-> (!crit_req_o && (main_req_o == '0)));

   // R8: pin 0 disabled means no critical request
   a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[11] |-> !crit_req_o);

   // R11: an asserted critical request implies pending, enabled, master on
   a_r11_req_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
      crit_req_o |-> (rd_data[27] && rd_data[11] && rd_data[12]));

   // R2: stored fields match the last write
   a_r2_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[23:16] == $past(wr_data[23:16]) &&
                 rd_data[12:8]  == $past(wr_data[12:8])  &&
                 rd_data[0]     == $past(wr_data[0])));

   // R2: reserved bits read zero
   a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[31:28] == 4'h0) && (rd_data[15:13] == 3'h0) && (rd_data[7:1] == 7'h0));

   // R5: a latched rising-edge request on pin 0 holds without a write
   a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data[23:22] == 2'b01) && ($past(rd_data[23:22]) == 2'b01) &&
       !$past(wr_en) && $past(rd_data[27])) |-> rd_data[27]);
endmodule

bind xirq_cond xirq_cond_chk #(.NPIN(NPIN), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .crit_req_o (crit_req_o),
   .main_req_o (main_req_o)
);

// File: tb/xirq_cond_tb_top.sv
`timescale 1ns/1ps
module xirq_cond_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  pin_i = '0;
   logic        crit_req_o;
   logic [2:0]  main_req_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xirq_cond dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .pin_i      (pin_i),
      .crit_req_o (crit_req_o),
      .main_req_o (main_req_o)
   );

   // Behavioural reference model
   logic [1:0] m_mode [4];
   logic [3:0] m_en = '0;
   logic       m_mee = 1'b0;
   logic       m_route = 1'b0;
   logic [3:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_lat = '0;

   initial for (int n = 0; n < 4; n++) m_mode[n] = 2'b00;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < 4; n++) m_mode[n] <= 2'b00;
         m_en <= '0; m_mee <= 1'b0; m_route <= 1'b0;
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_lat <= '0;
      end else begin
         for (int n = 0; n < 4; n++) begin
            bit got;
            bit wipe;
            got  = (m_mode[n] == 2'b01 && m_s2[n] && !m_prev[n]) ||
                   (m_mode[n] == 2'b10 && !m_s2[n] && m_prev[n]);
            wipe = wr_en && wr_data[27-n];
            if (m_mode[n] == 2'b01 || m_mode[n] == 2'b10)
               m_lat[n] <= got ? 1'b1 : (wipe ? 1'b0 : m_lat[n]);
            else
               m_lat[n] <= 1'b0;
         end
         m_prev <= m_s2;
         m_s2   <= m_s1;
         m_s1   <= pin_i;
         if (wr_en) begin
            for (int n = 0; n < 4; n++) begin
               m_mode[n] <= wr_data[23-2*n -: 2];
               m_en[n]   <= wr_data[11-n];
            end
            m_mee   <= wr_data[12];
            m_route <= wr_data[0];
         end
      end
   end

   function automatic logic [3:0] m_pend();
      logic [3:0] p;
      for (int n = 0; n < 4; n++) begin
         case (m_mode[n])
            2'b00:   p[n] = m_s2[n];
            2'b11:   p[n] = !m_s2[n];
            default: p[n] = m_lat[n];
         endcase
      end
      return p;
   endfunction

   function automatic logic [31:0] m_rd();
      logic [31:0] r;
      logic [3:0]  p;
      r = '0;
      p = m_pend();
      for (int n = 0; n < 4; n++) begin
         r[27-n]       = p[n];
         r[23-2*n -: 2] = m_mode[n];
         r[11-n]       = m_en[n];
      end
      r[12] = m_mee;
      r[0]  = m_route;
      return r;
   endfunction

   function automatic logic [3:0] m_req();
      logic [3:0] q;
      q = m_pend() & m_en & {4{m_mee}};
      return {q[3:1], q[0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10", rd_data, m_rd());
         chk("R11", {28'h0, main_req_o, crit_req_o}, {28'h0, m_req()});
      end
   end

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_run();
      end
   end

   initial begin
      idle(3);
      // R1: reset state
      chk("R1", rd_data, 32'h0);
      chk("R1", {31'h0, crit_req_o}, 32'h0);
      chk("R1", {29'h0, main_req_o}, 32'h0);
      rst_n = 1'b1;
      idle(2);

      // R2 / R4: all modes active-low, pins low
      wr(32'hFFFF_FFFF);
      chk("R2", rd_data, 32'h0FFF_1F01);
      chk("R4", {31'h0, crit_req_o}, 32'h1);
      chk("R4", {29'h0, main_req_o}, 32'h7);
      pin_i[0] = 1'b1;
      idle(3);
      chk("R4", {31'h0, crit_req_o}, 32'h0);

      // R3 / R11: active-high level
      wr(32'h0000_1F00);
      chk("R3", {31'h0, crit_req_o}, 32'h1);
      pin_i[2] = 1'b1;
      idle(3);
      chk("R11", {29'h0, main_req_o}, 32'h2);
      chk("R3", rd_data, 32'h0A00_1F00);
      pin_i = '0;
      idle(3);

      // R5 / R7 / R10: rising edge on pin 1
      wr(32'h0010_1F00);
      pin_i[1] = 1'b1;
      idle(4);
      chk("R5", {29'h0, main_req_o}, 32'h1);
      pin_i[1] = 1'b0;
      idle(4);
      chk("R5", {29'h0, main_req_o}, 32'h1);
      chk("R10", {31'h0, rd_data[26]}, 32'h1);
      wr(32'h0010_1F00);
      chk("R7", {29'h0, main_req_o}, 32'h1);
      wr(32'h0410_1F00);
      chk("R7", {29'h0, main_req_o}, 32'h0);
      chk("R7", {31'h0, rd_data[26]}, 32'h0);

      // R6: falling edge on pin 3
      pin_i[3] = 1'b1;
      idle(3);
      wr(32'h0002_1F00);
      pin_i[3] = 1'b0;
      idle(4);
      chk("R6", {29'h0, main_req_o}, 32'h4);
      wr(32'h0102_1F00);
      chk("R6", {29'h0, main_req_o}, 32'h0);

      // R8: pin 1 disabled still captures
      wr(32'h0010_1B00);
      pin_i[1] = 1'b1;
      idle(4);
      chk("R8", {29'h0, main_req_o}, 32'h0);
      chk("R8", {31'h0, rd_data[26]}, 32'h1);
      wr(32'h0010_1F00);
      chk("R8", {29'h0, main_req_o}, 32'h1);
      wr(32'h0410_1F00);
      pin_i[1] = 1'b0;
      idle(3);

      // R9: master enable off
      wr(32'h00FF_0F00);
      chk("R9", {31'h0, crit_req_o}, 32'h0);
      chk("R9", {29'h0, main_req_o}, 32'h0);
      chk("R9", {28'h0, rd_data[27:24]}, 32'hF);
      wr(32'h00FF_1F00);
      chk("R9", {31'h0, crit_req_o}, 32'h1);

      // R12: clear and new edge in the same cycle
      wr(32'h0040_1F00);
      idle(2);
      pin_i[0] = 1'b1;
      idle(2);
      wr(32'h0840_1F00);
      chk("R12", {31'h0, crit_req_o}, 32'h1);
      wr(32'h0840_1F00);
      chk("R7", {31'h0, crit_req_o}, 32'h0);

      idle(2);
      finish_run();
   end
endmodule